// File: doc/BRIEF.md
# Serial Flash Read Command Front-End

This block is the slave-side serial interface of a small flash device, reduced to its read path. The bus master pulls chip select low and clocks in an eight-bit opcode and a 24-bit address. The block then streams bytes from an internal memory out over the bus. It uses the single output line for the plain and fast read commands, and both data lines for the two dual-rate commands. The dual I/O command also receives its address on both lines, followed by a mode byte that the block discards.

All serial pins are oversampled in the system clock domain. Edges of the serial clock are detected against a registered copy of it, so the idle clock level does not matter and modes 0 and 3 behave the same. A hold input stops the transfer without deselecting the device: serial clock edges are ignored and the outputs float until hold is released. Bytes are fetched through a byte-wide read port. The port presents the address of the next byte and pulses a strobe in the cycle the byte is taken.

Top module: `spi_flash_rd_front`

## Requirements
- R1: Transfers work with the serial clock idling low or idling high at chip-select fall. Inputs are taken at rising serial clock edges, and outputs change only after falling edges.
- R2: Opcode and address bits are MSB first. Opcode 0x03 reads with no wait clocks. Bit 7 of the first byte appears on line 1 after the falling edge that follows the 32nd rising edge. Each byte takes 8 clocks.
- R3: Opcode 0x0B inserts 8 wait clocks after the address and then sends data on line 1, as R2 does.
- R4: Opcode 0x3B takes its address on line 0 and inserts 8 wait clocks. It then drives both lines, two bits per clock and 4 clocks per byte. Line 1 carries the odd bits (7, 5, 3, 1) and line 0 the even bits (6, 4, 2, 0). The output enable is never 2'b01.
- R5: Opcode 0xBB takes the address on both lines in 12 clocks, with the same bit mapping as R4. It ignores the next 4 clocks (the mode byte) and then sends data as R4 does.
- R6: The read address advances by one per byte and wraps from 0x0FFFFF to 0x000000. Address bits 23:20 are ignored.
- R7: Both output enables are 0 while chip select is high and during the opcode, address and wait phases.
- R8: Chip select going high aborts any partial command. The next selection starts a new command.
- R9: While hold is low and the device is selected, the command state is frozen and both output enables are 0. The transfer resumes where it stopped once hold returns high.
- R10: For any other opcode, no line is driven and no memory read is made until chip select rises.
- R11: After reset, both output enables and the read strobe are 0.
- R12: `mem_rd` pulses exactly once per byte sent, only in the data phase. `mem_rdata` is sampled in that cycle, and `mem_addr` has held the byte's address since at least the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| sio_in | input | 2 | Sampled levels of data lines 1 and 0 |
| sio_out | output | 2 | Values driven on data lines 1 and 0 |
| sio_oe | output | 2 | Output enables for data lines 1 and 0 |
| mem_addr | output | ADDR_W | Address of the next byte to send |
| mem_rd | output | 1 | Strobe: byte at mem_addr is taken this cycle |
| mem_rdata | input | 8 | Byte returned by the memory for mem_addr |

## Verification
Several faults show up as driven lines where the bus expects silence: a wrong phase counter, a bad opcode decode, or a lost dual-address flag. The enable would appear during the address or wait clocks, or the read would start one clock early or late. The first byte the master captures then shows a rotated or shifted bit pattern within one byte time. Errors in the address register or its wrap show up only at the byte after the faulty increment, so reads cross 0x0FFFFF. A hold leak shows up as a phase advanced by the garbage clocks sent during the pause, and so as corrupted data in the first byte after release.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_READ = 8'h03;
  localparam logic [OPC_W-1:0] OP_FAST = 8'h0B;
  localparam logic [OPC_W-1:0] OP_DOUT = 8'h3B;
  localparam logic [OPC_W-1:0] OP_DIO  = 8'hBB;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_DATA  = 3'd3,
    ST_SKIP  = 3'd4
  } rd_state_e;

  function automatic logic op_known(input logic [OPC_W-1:0] op);
    return (op == OP_READ) || (op == OP_FAST) || (op == OP_DOUT) || (op == OP_DIO);
  endfunction

  function automatic logic op_dual_addr(input logic [OPC_W-1:0] op);
    return op == OP_DIO;
  endfunction

  function automatic logic op_dual_data(input logic [OPC_W-1:0] op);
    return (op == OP_DOUT) || (op == OP_DIO);
  endfunction

endpackage

// File: rtl/spi_rd_edge.sv
module spi_rd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic hold_n,
  output logic rise,
  output logic fall
);

  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  // edges count only while selected and not paused
  logic live;
  assign live = !cs_n && hold_n;
  assign rise = live && sclk && !sclk_q;
  assign fall = live && !sclk && sclk_q;

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int XFER_ADDR_W = 24,
  parameter int FAST_DUMMY  = 8,
  parameter int MODE_CLKS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              rise,
  input  logic              byte_load,
  input  logic [1:0]        sio_in,
  output rd_state_e         state_o,
  output logic              dual_data_o,
  output logic [ADDR_W-1:0] mem_addr_o
);

  localparam int MAX_A    = (XFER_ADDR_W > OPC_W) ? XFER_ADDR_W : OPC_W;
  localparam int MAX_B    = (FAST_DUMMY > MODE_CLKS) ? FAST_DUMMY : MODE_CLKS;
  localparam int MAX_CLKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  rd_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [OPC_W-1:0]       op_q;
  logic [XFER_ADDR_W-1:0] addr_q;

  // one or two new bits per clock; in two-line mode line 1 holds the higher bit
  function automatic logic [XFER_ADDR_W-1:0] shift_addr(
    input logic [XFER_ADDR_W-1:0] sr, input logic [1:0] d, input logic dual);
    return dual ? {sr[XFER_ADDR_W-3:0], d[1], d[0]} : {sr[XFER_ADDR_W-2:0], d[0]};
  endfunction

  logic [OPC_W-1:0] op_next;
  logic [CNT_W-1:0] addr_last;
  logic [CNT_W-1:0] wait_clks;
  logic [ADDR_W-1:0] addr_inc;

  assign op_next   = {op_q[OPC_W-2:0], sio_in[0]};
  assign addr_last = op_dual_addr(op_q) ? CNT_W'(XFER_ADDR_W / 2 - 1) : CNT_W'(XFER_ADDR_W - 1);
  assign addr_inc  = addr_q[ADDR_W-1:0] + 1'b1;

  always_comb begin
    case (op_q)
      OP_FAST, OP_DOUT: wait_clks = CNT_W'(FAST_DUMMY);
      OP_DIO:           wait_clks = CNT_W'(MODE_CLKS);
      default:          wait_clks = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
    end else if (cs_n) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
    end else if (rise) begin
      case (state_q)
        ST_CMD: begin
          op_q <= op_next;
          if (cnt_q == CNT_W'(OPC_W - 1)) begin
            cnt_q   <= '0;
            state_q <= op_known(op_next) ? ST_ADDR : ST_SKIP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          addr_q <= shift_addr(addr_q, sio_in, op_dual_addr(op_q));
          if (cnt_q == addr_last) begin
            cnt_q   <= '0;
            state_q <= (wait_clks == '0) ? ST_DATA : ST_DUMMY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          if (cnt_q == wait_clks - 1'b1) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (byte_load && state_q == ST_DATA) begin
      addr_q[ADDR_W-1:0] <= addr_inc;
    end
  end

  assign state_o     = state_q;
  assign dual_data_o = op_dual_data(op_q);
  assign mem_addr_o  = addr_q[ADDR_W-1:0];

  // R9: a paused transfer keeps its place
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !hold_n) |=> ($stable(state_q) && $stable(cnt_q) && $stable(addr_q)));

  // R8: deselect returns to a fresh opcode phase
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (state_q == ST_CMD && cnt_q == '0));

  // R6: address wraps at the top of the space
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && state_q == ST_DATA && addr_q[ADDR_W-1:0] == {ADDR_W{1'b1}})
      |=> addr_q[ADDR_W-1:0] == '0);

endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              fall,
  input  logic              in_data,
  input  logic              dual,
  input  logic [DATA_W-1:0] rdata,
  output logic              byte_load,
  output logic [1:0]        sio_out,
  output logic [1:0]        sio_oe
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              live_q;
  logic [1:0]        oe_q;
  logic [CNT_W-1:0]  per_last;

  assign per_last  = dual ? CNT_W'(DATA_W / 2 - 1) : CNT_W'(DATA_W - 1);
  assign byte_load = fall && in_data && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
      oe_q   <= 2'b00;
    end else begin
      if (cs_n || !in_data) begin
        cnt_q  <= '0;
        live_q <= 1'b0;
      end else if (fall) begin
        if (cnt_q == '0) begin
          sr_q   <= rdata;
          cnt_q  <= per_last;
          live_q <= 1'b1;
        end else begin
          sr_q  <= dual ? (sr_q << 2) : (sr_q << 1);
          cnt_q <= cnt_q - 1'b1;
        end
      end
      oe_q <= (!cs_n && hold_n && in_data && (live_q || byte_load))
              ? (dual ? 2'b11 : 2'b10) : 2'b00;
    end
  end

  assign sio_out = {sr_q[DATA_W-1], dual ? sr_q[DATA_W-2] : 1'b0};
  assign sio_oe  = oe_q;

  // R4: line 0 is never driven alone
  p_oe_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe != 2'b01);

  // R9: pause floats the lines
  p_hold_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> sio_oe == 2'b00);

  // R12: one fetch per byte
  p_single_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> !byte_load);

endmodule

// File: rtl/spi_flash_rd_front.sv
module spi_flash_rd_front
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int XFER_ADDR_W = 24,
  parameter int FAST_DUMMY  = 8,
  parameter int MODE_CLKS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic [1:0]        sio_in,
  output logic [1:0]        sio_out,
  output logic [1:0]        sio_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata
);

  logic      rise;
  logic      fall;
  logic      byte_load;
  logic      dual_data;
  rd_state_e state;

  spi_rd_edge edge_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n),
    .rise(rise), .fall(fall)
  );

  spi_rd_ctrl #(
    .ADDR_W(ADDR_W), .XFER_ADDR_W(XFER_ADDR_W),
    .FAST_DUMMY(FAST_DUMMY), .MODE_CLKS(MODE_CLKS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .rise(rise),
    .byte_load(byte_load), .sio_in(sio_in), .state_o(state),
    .dual_data_o(dual_data), .mem_addr_o(mem_addr)
  );

  spi_rd_tx #(.DATA_W(8)) tx_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .fall(fall),
    .in_data(state == ST_DATA), .dual(dual_data), .rdata(mem_rdata),
    .byte_load(byte_load), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  assign mem_rd = byte_load;

  // R7: nothing driven once deselected
  p_idle_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> sio_oe == 2'b00);

  // R7: nothing driven before the data phase
  p_quiet_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DATA) |-> sio_oe == 2'b00);

  // R10: an unknown opcode never reads memory
  p_skip_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !mem_rd);

  // R12: fetches only in the data phase
  p_rd_in_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> state == ST_DATA);

endmodule

// File: tb/spi_flash_rd_front_tb.sv
`timescale 1ns/1ps
module spi_flash_rd_front_tb_top;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, cs_n, hold_n;
  logic [1:0]  sio_in;
  logic [1:0]  sio_out, sio_oe;
  logic [19:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  always @(posedge clk) if (mem_rd) rd_cnt <= rd_cnt + 1;

  spi_flash_rd_front dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock: low phase (drive, sample), then high phase
  task automatic tick(input logic [1:0] din, output logic [1:0] q, output logic [1:0] oe);
    @(negedge clk);
    sclk = 1'b0;
    sio_in = din;
    wt(H);
    q = sio_out;
    oe = sio_oe;
    sclk = 1'b1;
    wt(H);
  endtask

  task automatic start(input bit m3);
    @(negedge clk);
    sclk = m3;
    cs_n = 1'b1;
    wt(H);
    cs_n = 1'b0;
    wt(H);
  endtask

  task automatic stop(input bit m3);
    @(negedge clk);
    sclk = m3;
    wt(H);
    cs_n = 1'b1;
    wt(H);
  endtask

  task automatic pause(input logic [1:0] exp_oe, input string req);
    @(negedge clk);
    hold_n = 1'b0;
    wt(H);
    chk(sio_oe == 2'b00, req, sio_oe, 0);
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk;
      sio_in = 2'(i);
      wt(H);
    end
    hold_n = 1'b1;
    wt(H);
    chk(sio_oe == exp_oe, req, sio_oe, exp_oe);
  endtask

  task automatic do_read(input bit m3, input logic [7:0] op, input logic [23:0] a,
                         input int n, input string req, input bit hold_a, input bit hold_d);
    logic [1:0] q, oe;
    logic [7:0] got;
    logic [19:0] ea;
    logic [1:0] exp_oe;
    bit quiet, oe_ok;
    int base, nwait;
    bit dual;
    dual = (op == 8'h3B) || (op == 8'hBB);
    exp_oe = dual ? 2'b11 : 2'b10;
    nwait = (op == 8'h03) ? 0 : (op == 8'hBB) ? 4 : 8;
    quiet = 1;
    start(m3);
    base = rd_cnt;
    for (int i = 7; i >= 0; i--) begin
      tick({1'b0, op[i]}, q, oe);
      if (oe != 2'b00) quiet = 0;
    end
    if (op == 8'hBB) begin
      for (int k = 11; k >= 0; k--) begin
        tick(a[2*k +: 2], q, oe);
        if (oe != 2'b00) quiet = 0;
        if (hold_a && k == 6) pause(2'b00, "R9");
      end
    end else begin
      for (int i = 23; i >= 0; i--) begin
        tick({1'b0, a[i]}, q, oe);
        if (oe != 2'b00) quiet = 0;
        if (hold_a && i == 12) pause(2'b00, "R9");
      end
    end
    for (int j = 0; j < nwait; j++) begin
      tick(2'b10, q, oe);
      if (oe != 2'b00) quiet = 0;
    end
    chk(quiet, "R7 quiet before data", 0, 0);
    for (int b = 0; b < n; b++) begin
      ea = a[19:0] + 20'(b);
      got = '0;
      oe_ok = 1;
      if (dual) begin
        for (int k = 0; k < 4; k++) begin
          tick(2'b00, q, oe);
          got = {got[5:0], q[1], q[0]};
          if (oe != 2'b11) oe_ok = 0;
        end
      end else begin
        for (int k = 0; k < 8; k++) begin
          tick(2'b00, q, oe);
          got = {got[6:0], q[1]};
          if (oe != 2'b10) oe_ok = 0;
        end
      end
      chk(got == mem_byte(ea), req, got, mem_byte(ea));
      chk(oe_ok, {req, " enable"}, 0, 0);
      if (hold_d && b == 0) pause(exp_oe, "R9");
    end
    chk(rd_cnt - base == n, "R12 fetch count", rd_cnt - base, n);
    stop(m3);
    chk(sio_oe == 2'b00, "R7 idle", sio_oe, 0);
  endtask

  task automatic t_reset;
    chk(sio_oe == 2'b00, "R11 oe", sio_oe, 0);
    chk(mem_rd == 1'b0, "R11 rd", mem_rd, 0);
  endtask

  task automatic t_abort;
    logic [1:0] q, oe;
    start(0);
    for (int i = 7; i >= 0; i--) tick({1'b0, 8'h03 >> i}, q, oe);
    for (int i = 0; i < 10; i++) tick(2'b01, q, oe);
    stop(0);
    chk(sio_oe == 2'b00, "R8 abort idle", sio_oe, 0);
    do_read(0, 8'h03, 24'h013579, 2, "R8 after abort", 0, 0);
  endtask

  task automatic t_unknown;
    logic [1:0] q, oe;
    bit quiet;
    int base;
    quiet = 1;
    start(0);
    base = rd_cnt;
    for (int i = 7; i >= 0; i--) tick({1'b0, 8'h55 >> i}, q, oe);
    for (int i = 0; i < 48; i++) begin
      tick(2'b11, q, oe);
      if (oe != 2'b00) quiet = 0;
    end
    chk(quiet, "R10 no drive", 0, 0);
    chk(rd_cnt == base, "R10 no fetch", rd_cnt - base, 0);
    stop(0);
    do_read(1, 8'h0B, 24'h0ACE00, 1, "R10 recover", 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sclk = 1'b0;
    cs_n = 1'b1;
    hold_n = 1'b1;
    sio_in = 2'b00;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    t_reset();
    do_read(0, 8'h03, 24'h012345, 3, "R2", 0, 0);
    do_read(1, 8'h03, 24'h0ABCDE, 2, "R1 mode3", 0, 0);
    do_read(0, 8'h0B, 24'h054321, 2, "R3", 0, 0);
    do_read(1, 8'h0B, 24'h000010, 2, "R3 mode3", 0, 0);
    do_read(0, 8'h3B, 24'h0F00F0, 3, "R4", 0, 0);
    do_read(1, 8'hBB, 24'h0777AA, 3, "R5", 0, 0);
    do_read(0, 8'hBB, 24'h0C3A51, 2, "R5 mode0", 0, 0);
    do_read(0, 8'h03, 24'h0FFFFE, 3, "R6 wrap", 0, 0);
    do_read(0, 8'h3B, 24'hF12345, 2, "R6 upper", 0, 0);
    do_read(0, 8'h03, 24'h022222, 2, "R9", 1, 1);
    do_read(0, 8'hBB, 24'h0468AC, 2, "R9 dual", 1, 1);
    t_abort();
    t_unknown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule